// File: doc/BRIEF.md
# I2S receive frame controller

This block runs the receive side of a serial audio port. As master it drives the bit clock and the frame sync. As slave it takes both from outside. Each incoming frame is shifted in and pushed as one word into a small receive FIFO. Software reads that FIFO through a first-word-fall-through read port.

Two bits gate all activity: a global start and a receive enable. A mode pin selects master or slave. A second pin selects free-running operation, where syncs recur at a programmed period, or burst operation, where syncs occur on demand. Three sticky status flags report FIFO overrun, FIFO underrun and frame-timing errors. Software clears each flag by writing 1 to its clear bit.

All pins are sampled in the system clock domain. In slave mode the external bit clock is oversampled, and its rising edges are detected from two consecutive samples.

Top module: `i2s_rx_frame_ctrl`

## Requirements
- R1: After reset the FIFO is empty (empty_o=1, full_o=0), all three flags read 0, and sck_o and fs_o are 0.
- R2: A frame is len_m1_i+1 bits (1 to 32), sampled on rising serial-clock edges, most significant bit first. The first bit is the one sampled at the edge where the sync is high. The word is written right-aligned and zero-extended.
- R3: In slave mode, when start_i and rxen_i are both 1, each sync seen at a rising edge while no frame is in progress starts one frame. When either bit is 0, syncs are ignored and nothing enters the FIFO.
- R4: In slave burst mode (frun_i=0), a sync during a frame in progress sets the frame-error flag. It does not restart the frame; its bit is kept as data.
- R5: In slave free-running mode (frun_i=1), after an accepted sync the next sync must come exactly period_i rising edges later. An early sync, or none at that edge, sets the frame-error flag.
- R6: In master free-running mode, while start_i=1, fs_o is high for one bit period in every period_i bit periods, whatever rxen_i is. Frames are stored only when rxen_i=1.
- R7: In master burst mode, fs_o is high only while start_i and rxen_i are 1, no frame is in progress and the FIFO is not full. Frames therefore stop when the FIFO fills, and no overrun occurs.
- R8: While start_i=0 or rxen_i=0 the FIFO is flushed and stays empty.
- R9: In master mode, sck_o toggles on every system clock while start_i=1 and is held at 0 while start_i=0. In slave mode sck_o is 0.
- R10: A word completed while the FIFO is full is dropped, and the overrun flag (ovr_o) is set.
- R11: A read (rd_en_i=1) while the FIFO is empty sets the underrun flag (udr_o).
- R12: The flags are sticky. clr_i bit 0 clears overrun, bit 1 clears underrun and bit 2 clears frame error. A set in the same cycle wins.
- R13: The FIFO holds 8 words in arrival order. rd_data_o shows the oldest word, and full_o and empty_o reflect its occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Global run bit |
| rxen_i | input | 1 | Receive enable |
| master_i | input | 1 | 1 = master, 0 = slave |
| frun_i | input | 1 | 1 = free-running, 0 = burst |
| len_m1_i | input | 5 | Frame length minus one |
| period_i | input | 10 | Frame period in bit periods |
| sck_i | input | 1 | Bit clock from outside (slave) |
| fs_i | input | 1 | Frame sync from outside (slave) |
| sd_i | input | 1 | Serial data |
| sck_o | output | 1 | Bit clock driven out (master) |
| fs_o | output | 1 | Frame sync driven out (master) |
| rd_en_i | input | 1 | FIFO read strobe |
| rd_data_o | output | 32 | Oldest FIFO word |
| empty_o | output | 1 | FIFO empty |
| full_o | output | 1 | FIFO full |
| clr_i | input | 3 | Write-1 flag clear {ferr, udr, ovr} |
| ovr_o | output | 1 | Sticky overrun |
| udr_o | output | 1 | Sticky underrun |
| ferr_o | output | 1 | Sticky frame error |

## Verification
In slave burst mode, a sync arriving in the middle of a frame lands on the same rising edge as that frame's next data bit. The bench sends a byte with a second sync on its fifth bit. It then judges two things together: the frame-error flag must rise, and the scoreboard must still receive the unbroken byte. In master free-running mode, FIFO writes and scoreboard reads meet in the same cycles, and the popped words must keep their order.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  typedef struct packed {
    logic ferr;
    logic udr;
    logic ovr;
  } rxfc_flags_t;

  localparam int FLAG_N = 3;
endpackage

// File: rtl/rxfc_fifo.sv
module rxfc_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_wr, do_rd;

  always_comb begin
    full  = (cnt_q == (AW+1)'(DEPTH));
    empty = (cnt_q == '0);
    do_wr = wr & ~full & ~flush;
    do_rd = rd & ~empty & ~flush;
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_wr) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end
    rdata = mem[rp_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end

  a_r13_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/rxfc_clkgen.sv
module rxfc_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic master,
  input  logic sck_i,
  output logic sck_o,
  output logic tick
);
  logic sck_q, sck_d, smp_q;

  always_comb begin
    sck_d = (start & master) ? ~sck_q : 1'b0;
    tick  = start & (master ? ~sck_q : (sck_i & ~smp_q));
    sck_o = sck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      smp_q <= 1'b0;
    end else begin
      sck_q <= sck_d;
      smp_q <= sck_i;
    end
  end

  a_r9_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !sck_o);
endmodule

// File: rtl/rxfc_framer.sv
module rxfc_framer #(
  parameter int DW    = 32,
  parameter int PW    = 10,
  localparam int LENW = $clog2(DW),
  localparam int CW   = LENW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            start,
  input  logic            rxen,
  input  logic            master,
  input  logic            frun,
  input  logic [LENW-1:0] len_m1,
  input  logic [PW-1:0]   period,
  input  logic            fs_i,
  input  logic            sd_i,
  input  logic            fifo_full,
  output logic            fs_o,
  output logic            wr_o,
  output logic [DW-1:0]   wdata_o,
  output logic            ferr_set_o
);
  logic          busy_q, busy_d;
  logic [CW-1:0] bcnt_q, bcnt_d, taken;
  logic [DW-1:0] sh_q, sh_d, sh_n;
  logic [PW-1:0] pcnt_q, pcnt_d, scnt_q, scnt_d, last_p;
  logic          armed_q, armed_d;
  logic          gate, sync, sof, take, eof, chk_en, err_burst, err_free;

  always_comb begin
    gate   = start & rxen;
    last_p = period - 1'b1;
    if (!master)   fs_o = 1'b0;
    else if (frun) fs_o = start & (pcnt_q == '0);
    else           fs_o = gate & ~busy_q & ~fifo_full;
    sync  = master ? fs_o : fs_i;
    sof   = tick & gate & sync & ~busy_q;
    take  = tick & gate & (busy_q | sof);
    sh_n  = sof ? {{(DW-1){1'b0}}, sd_i} : {sh_q[DW-2:0], sd_i};
    taken = sof ? CW'(1) : bcnt_q + 1'b1;
    eof   = take & (taken == ({1'b0, len_m1} + 1'b1));
    wr_o    = eof;
    wdata_o = sh_n;

    busy_d = busy_q;
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    if (!gate) begin
      busy_d = 1'b0;
      bcnt_d = '0;
    end else if (take) begin
      busy_d = ~eof;
      bcnt_d = eof ? '0 : taken;
      sh_d   = sh_n;
    end

    pcnt_d = pcnt_q;
    if (!(start & master & frun)) pcnt_d = '0;
    else if (tick)                pcnt_d = (pcnt_q == last_p) ? '0 : pcnt_q + 1'b1;

    chk_en    = gate & ~master & frun;
    err_burst = tick & gate & ~master & ~frun & fs_i & busy_q;
    err_free  = 1'b0;
    scnt_d    = scnt_q;
    armed_d   = armed_q;
    if (!chk_en) begin
      scnt_d  = '0;
      armed_d = 1'b0;
    end else if (tick) begin
      if (fs_i) begin
        err_free = armed_q & (scnt_q != last_p);
        scnt_d   = '0;
        armed_d  = 1'b1;
      end else if (armed_q) begin
        if (scnt_q == last_p) begin
          err_free = 1'b1;
          armed_d  = 1'b0;
          scnt_d   = '0;
        end else begin
          scnt_d = scnt_q + 1'b1;
        end
      end
    end
    ferr_set_o = err_burst | err_free;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      pcnt_q  <= '0;
      scnt_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      bcnt_q  <= bcnt_d;
      sh_q    <= sh_d;
      pcnt_q  <= pcnt_d;
      scnt_q  <= scnt_d;
      armed_q <= armed_d;
    end
  end

  a_r2_word_closes_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> !busy_q);
  a_r7_burst_sync_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !frun && fs_o) |-> (gate && !fifo_full));
endmodule

// File: rtl/i2s_rx_frame_ctrl.sv
module i2s_rx_frame_ctrl #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int PW    = 10,
  localparam int LENW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            rxen_i,
  input  logic            master_i,
  input  logic            frun_i,
  input  logic [LENW-1:0] len_m1_i,
  input  logic [PW-1:0]   period_i,
  input  logic            sck_i,
  input  logic            fs_i,
  input  logic            sd_i,
  output logic            sck_o,
  output logic            fs_o,
  input  logic            rd_en_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            empty_o,
  output logic            full_o,
  input  logic [2:0]      clr_i,
  output logic            ovr_o,
  output logic            udr_o,
  output logic            ferr_o
);
  import rxfc_pkg::*;

  logic          rs0_q, rs1_q, rst_sn;
  logic          tick, fwr, ffull, fempty, ferr_set, flush;
  logic [DW-1:0] fwdata;
  rxfc_flags_t   flg_q, flg_d, set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_sn = rs1_q;

  rxfc_clkgen u_clk (
    .clk    (clk),
    .rst_n  (rst_sn),
    .start  (start_i),
    .master (master_i),
    .sck_i  (sck_i),
    .sck_o  (sck_o),
    .tick   (tick)
  );

  rxfc_framer #(.DW(DW), .PW(PW)) u_frm (
    .clk        (clk),
    .rst_n      (rst_sn),
    .tick       (tick),
    .start      (start_i),
    .rxen       (rxen_i),
    .master     (master_i),
    .frun       (frun_i),
    .len_m1     (len_m1_i),
    .period     (period_i),
    .fs_i       (fs_i),
    .sd_i       (sd_i),
    .fifo_full  (ffull),
    .fs_o       (fs_o),
    .wr_o       (fwr),
    .wdata_o    (fwdata),
    .ferr_set_o (ferr_set)
  );

  assign flush = ~(start_i & rxen_i);

  rxfc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sn),
    .flush (flush),
    .wr    (fwr),
    .wdata (fwdata),
    .rd    (rd_en_i),
    .rdata (rd_data_o),
    .full  (ffull),
    .empty (fempty)
  );

  always_comb begin
    set_v.ovr  = fwr & ffull & ~flush;
    set_v.udr  = rd_en_i & fempty;
    set_v.ferr = ferr_set;
    flg_d      = (flg_q & ~rxfc_flags_t'(clr_i)) | set_v;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) flg_q <= '0;
    else         flg_q <= flg_d;
  end

  assign ovr_o   = flg_q.ovr;
  assign udr_o   = flg_q.udr;
  assign ferr_o  = flg_q.ferr;
  assign empty_o = fempty;
  assign full_o  = ffull;

  a_r10_overrun_flags: assert property (@(posedge clk) disable iff (!rst_sn)
    (fwr && ffull && !flush) |=> ovr_o);
  a_r11_underrun_flags: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en_i && fempty) |=> udr_o);
  a_r12_clear_works: assert property (@(posedge clk) disable iff (!rst_sn)
    (clr_i[2] && !ferr_set) |=> !ferr_o);
endmodule

// File: tb/sim_i2s_rx_frame_ctrl.sv
module sim_i2s_rx_frame_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, rxen_i = 0, master_i = 0, frun_i = 0;
  logic [4:0] len_m1_i = 5'd7;
  logic [9:0] period_i = 10'd10;
  logic sck_i = 0, fs_i = 0, sd_i = 0;
  logic sck_o, fs_o, empty_o, full_o, ovr_o, udr_o, ferr_o;
  logic rd_req = 0, mon_rd = 0, rd_en_i;
  logic [31:0] rd_data_o;
  logic [2:0] clr_i = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];

  assign rd_en_i = rd_req | mon_rd;
  always #(CLK_P/2) clk = ~clk;

  i2s_rx_frame_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rxen_i(rxen_i),
    .master_i(master_i), .frun_i(frun_i), .len_m1_i(len_m1_i),
    .period_i(period_i), .sck_i(sck_i), .fs_i(fs_i), .sd_i(sd_i),
    .sck_o(sck_o), .fs_o(fs_o), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .empty_o(empty_o), .full_o(full_o), .clr_i(clr_i),
    .ovr_o(ovr_o), .udr_o(udr_o), .ferr_o(ferr_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops the oldest word whenever an expectation is queued (R2, R13)
  always @(negedge clk) begin
    mon_rd = 1'b0;
    if (exp_q.size() > 0 && !empty_o) begin
      chk("R13 R2 scoreboard word", rd_data_o, exp_q[0]);
      void'(exp_q.pop_front());
      mon_rd = 1'b1;
    end
  end

  task automatic sbit(logic f, logic d);
    @(negedge clk); sck_i = 0; fs_i = f; sd_i = d;
    @(negedge clk);
    @(negedge clk); sck_i = 1;
    @(negedge clk);
  endtask

  task automatic sframe(logic [31:0] w, int len, bit push);
    for (int i = len - 1; i >= 0; i--) sbit(i == len - 1, w[i]);
    if (push) exp_q.push_back(w);
  endtask

  task automatic drain();
    for (int k = 0; k < 2000 && exp_q.size() > 0; k++) @(negedge clk);
    chk("R13 drain complete", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic clr(logic [2:0] b);
    @(negedge clk); clr_i = b;
    @(negedge clk); clr_i = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 empty", 32'(empty_o), 1); chk("R1 full", 32'(full_o), 0);
    chk("R1 flags", {29'd0, ferr_o, udr_o, ovr_o}, 0);
    chk("R1 sck/fs", {30'd0, sck_o, fs_o}, 0);

    // R3 slave gated off: rxen=0 ignores syncs
    start_i = 1; master_i = 0; frun_i = 0; len_m1_i = 7;
    sframe(32'h5A, 8, 0);
    repeat (2) @(negedge clk);
    chk("R3 ignored when disabled", 32'(empty_o), 1);

    // R2 R3 slave burst capture, several lengths
    rxen_i = 1;
    sframe(32'hA5, 8, 1); sbit(0, 0);
    sframe(32'h3C, 8, 1);
    len_m1_i = 31; sframe(32'hDEADBEEF, 32, 1);
    len_m1_i = 0;  sframe(32'h1, 1, 1); sframe(32'h0, 1, 1);
    drain();
    chk("R2 no stray error", 32'(ferr_o), 0);

    // R4 mid-frame sync in burst: error, frame continues
    len_m1_i = 7;
    for (int i = 7; i >= 0; i--) sbit(i == 7 || i == 3, 1'(8'h96 >> i));
    exp_q.push_back(32'h96);
    @(negedge clk);
    chk("R4 ferr on early sync", 32'(ferr_o), 1);
    drain();
    clr(3'b100);
    chk("R12 ferr cleared", 32'(ferr_o), 0);

    // R5 slave free-running period check, period 10, len 8
    frun_i = 1; period_i = 10;
    for (int k = 0; k < 3; k++) begin
      sframe(32'h10 + 32'(k), 8, 1); sbit(0, 0); sbit(0, 0);
    end
    chk("R5 on-time syncs no error", 32'(ferr_o), 0);
    sframe(32'h20, 8, 1); sbit(0, 0);
    sframe(32'h21, 8, 1);
    @(negedge clk);
    chk("R5 early sync error", 32'(ferr_o), 1);
    drain();
    clr(3'b100);
    for (int k = 0; k < 10; k++) sbit(0, 0);
    @(negedge clk);
    chk("R5 missing sync error", 32'(ferr_o), 1);
    clr(3'b100);

    // R10 R13 overflow in slave burst
    frun_i = 0; len_m1_i = 3;
    for (int k = 1; k <= 8; k++) sframe(32'(k), 4, 0);
    chk("R13 full after 8", 32'(full_o), 1);
    chk("R10 no overrun yet", 32'(ovr_o), 0);
    sframe(32'h9, 4, 0);
    @(negedge clk);
    chk("R10 overrun set", 32'(ovr_o), 1);
    for (int k = 1; k <= 8; k++) exp_q.push_back(32'(k));
    drain();
    @(negedge clk);
    chk("R10 dropped word absent", 32'(empty_o), 1);

    // R11 underflow, R12 clears
    @(negedge clk); rd_req = 1; @(negedge clk); rd_req = 0;
    chk("R11 underrun set", 32'(udr_o), 1);
    clr(3'b010);
    chk("R12 udr cleared", 32'(udr_o), 0);
    chk("R12 ovr kept", 32'(ovr_o), 1);
    clr(3'b001);
    chk("R12 ovr cleared", 32'(ovr_o), 0);

    // R8 flush on rxen drop
    sframe(32'h7, 4, 0);
    chk("R8 word present", 32'(empty_o), 0);
    @(negedge clk); rxen_i = 0; @(negedge clk);
    chk("R8 flushed", 32'(empty_o), 1);
    chk("R9 slave sck_o low", 32'(sck_o), 0);

    // R6 master free-running
    master_i = 1; frun_i = 1; len_m1_i = 3; period_i = 6; sd_i = 1;
    begin
      int cnt = 0;
      while (fs_o !== 1'b0) @(negedge clk);
      while (fs_o !== 1'b1) @(negedge clk);
      while (fs_o !== 1'b0) @(negedge clk);
      cnt = 0;
      while (fs_o !== 1'b1 && cnt < 100) begin @(negedge clk); cnt++; end
      // distance from fall to next rise is (period-1) bit periods of 2 clocks
      chk("R6 sync spacing", 32'(cnt + 2), 32'd12);
    end
    chk("R6 no capture with rxen=0", 32'(empty_o), 1);
    for (int k = 0; k < 3; k++) exp_q.push_back(32'hF);
    rxen_i = 1;
    drain();
    repeat (40) @(negedge clk);
    chk("R6 words keep arriving", 32'(empty_o), 0);
    rxen_i = 0; @(negedge clk);
    chk("R8 flush master", 32'(empty_o), 1);

    // R7 master burst stops when full
    frun_i = 0; rxen_i = 1;
    repeat (200) @(negedge clk);
    chk("R7 fifo filled", 32'(full_o), 1);
    begin
      int hits = 0;
      for (int k = 0; k < 50; k++) begin @(negedge clk); if (fs_o) hits++; end
      chk("R7 no sync while full", 32'(hits), 0);
    end
    chk("R7 no overrun", 32'(ovr_o), 0);
    for (int k = 0; k < 8; k++) exp_q.push_back(32'hF);
    drain();

    // R9 start=0 parks the clock and flushes
    start_i = 0; @(negedge clk); @(negedge clk);
    begin
      int hi = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (sck_o) hi++; end
      chk("R9 sck parked", 32'(hi), 0);
    end
    chk("R8 flushed on stop", 32'(empty_o), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule